// File: doc/BRIEF.md
# Dual-Organization Static Memory Array

This block is a clocked, synthesizable model of a bit-wide static memory. Three active-low controls steer it: chip select (`csN`), write strobe (`weN`) and output enable (`oeN`). All of them are sampled on the rising clock edge. The strobes behave as they would on an asynchronous part, so the block can replace such a memory in a cycle-based environment.

The output is registered. The flag `dOutEn` stands in for the tri-state driver: when it is low the bus counts as released.

A mode input, `wideMode`, selects how the single bit store is organized. With `wideMode` low there are 2^ADDR_W words of one bit. With `wideMode` high there are 2^(ADDR_W-2) words of four bits, and the two most significant address bits are ignored. Wide word `w` covers bit cells 4w to 4w+3, so data written in one organization can be read back in the other.

Each cell carries a written-since-reset flag. A read that touches any unwritten cell is reported as invalid and its data is masked.

Top module: `dualOrgSram`

## Requirements
- R1: When `csN` is sampled high, no write takes place. One cycle later `dOutEn` is 0, whatever `weN` and `oeN` are.
- R2: A write is active while `csN` and `weN` are both sampled low. It commits on the first edge at which either strobe is sampled high. The data stored is `dIn` sampled at that commit edge. The address and mode stored are those sampled during the last active cycle.
- R3: When `csN`=0, `weN`=1 and `oeN`=0 are sampled, `dOutEn` is 1 one cycle later and `dOut` carries the addressed data. In narrow mode the bit is on `dOut[0]` and `dOut[3:1]` is 0.
- R4: When `csN`=0, `weN`=1 and `oeN`=1 are sampled, `dOutEn` is 0 one cycle later and nothing is written.
- R5: During an active write, `dOutEn` is 0 one cycle later, even when `oeN` is 0.
- R6: With `wideMode`=0, each of the 2^ADDR_W addresses holds one bit. With `wideMode`=1, words are four bits wide, only `addr[ADDR_W-3:0]` selects the word, and the top two address bits have no effect.
- R7: If `weN` is already low when `csN` is first sampled low, `dOutEn` stays 0 until `csN` is sampled high again. This holds even after `weN` rises with `oeN` low.
- R8: Wide word w, bit i, is bit cell 4w+i. Data written in one mode reads back in the other mode under this mapping.
- R9: A read that touches any cell not written since reset gives `dOutValid`=0 and `dOut`=0. Otherwise `dOutValid`=1 with the read.
- R10: The address sampled on two consecutive active-write cycles must be equal.
- R11: After reset, `dOutEn`, `dOutValid` and `dOut` are 0 and no cell counts as written.
- R12: A read sampled on the same edge as a write commit returns the contents from before that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| wideMode | input | 1 | 0: one-bit words, 1: four-bit words |
| addr | input | ADDR_W | Address (bit cell or wide word) |
| dIn | input | 4 | Write data; only bit 0 is used in narrow mode |
| dOut | output | 4 | Registered read data |
| dOutEn | output | 1 | Output driven (low means released) |
| dOutValid | output | 1 | Read data comes only from written cells |

## Verification
Several rules are checked on every cycle by the assertions:
- the output is released after a deselect, after output enable high, during a write, and after a select that arrives with the strobe already low;
- masked data is zero whenever it is invalid;
- the address is held steady across a write.

The bench scenarios are needed for the rest:
- which data a commit actually stores (trailing-edge data, strobe-controlled versus select-controlled ending);
- the cross-mode bit mapping and the ignored top address bits in wide mode;
- read-before-write ordering on a commit edge.

// File: rtl/dosPkg.sv
package dosPkg;
  localparam int LANES = 4;

  typedef struct packed {
    logic commit;      // write finishes on this edge
    logic commitWide;  // organization used for the finishing write
    logic rdReq;       // drive output on next cycle
    logic rdWide;      // organization used for the read
  } dosStrobes_t;
endpackage

// File: rtl/dosControl.sv
module dosControl
  import dosPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              wideMode,
  input  logic [ADDR_W-1:0] addr,
  output dosStrobes_t       strb,
  output logic [ADDR_W-1:0] wAddr
);
  logic csPrevQ;
  logic activeQ;
  logic wideQ;
  logic blockQ;
  logic [ADDR_W-1:0] wAddrQ;

  logic activeNow;
  logic blockNext;

  assign activeNow = !csN && !weN;

  // select arriving with the strobe already low keeps the bus released
  always_comb begin
    if (csN)                          blockNext = 1'b0;
    else if (csPrevQ && !weN)         blockNext = 1'b1;
    else                              blockNext = blockQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrevQ <= 1'b1;
      activeQ <= 1'b0;
      wideQ   <= 1'b0;
      blockQ  <= 1'b0;
      wAddrQ  <= '0;
    end else begin
      csPrevQ <= csN;
      activeQ <= activeNow;
      blockQ  <= blockNext;
      if (activeNow) begin
        wAddrQ <= addr;
        wideQ  <= wideMode;
      end
    end
  end

  always_comb begin
    strb.commit     = activeQ && !activeNow;
    strb.commitWide = wideQ;
    strb.rdReq      = !csN && weN && !oeN && !blockNext;
    strb.rdWide     = wideMode;
  end

  assign wAddr = wAddrQ;
endmodule

// File: rtl/dosDatapath.sv
module dosDatapath
  import dosPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dosStrobes_t       strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [LANES-1:0]  dIn,
  output logic [LANES-1:0]  dOut,
  output logic              dOutEn,
  output logic              dOutValid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WORD_W = ADDR_W - 2;

  logic [DEPTH-1:0] memBits;
  logic [DEPTH-1:0] written;

  logic [LANES-1:0] rdBits;
  logic [LANES-1:0] rdHit;
  logic             rdKnown;

  logic [ADDR_W-1:0] wrIdx [LANES];
  logic [LANES-1:0]  wrLaneEn;

  genvar lane;
  generate
    for (lane = 0; lane < LANES; lane++) begin : gLane
      logic [ADDR_W-1:0] rdIdx;
      assign rdIdx = strb.rdWide ? {addr[WORD_W-1:0], 2'(lane)} : addr;
      if (lane == 0) begin : gNarrowLane
        assign rdBits[lane] = memBits[rdIdx];
        assign rdHit[lane]  = written[rdIdx];
        assign wrIdx[lane]  = strb.commitWide ? {wAddr[WORD_W-1:0], 2'(lane)} : wAddr;
        assign wrLaneEn[lane] = strb.commit;
      end else begin : gWideLane
        assign rdBits[lane] = strb.rdWide ? memBits[rdIdx] : 1'b0;
        assign rdHit[lane]  = strb.rdWide ? written[rdIdx] : 1'b1;
        assign wrIdx[lane]  = {wAddr[WORD_W-1:0], 2'(lane)};
        assign wrLaneEn[lane] = strb.commit && strb.commitWide;
      end
    end
  endgenerate

  assign rdKnown = &rdHit;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (wrLaneEn[i]) memBits[wrIdx[i]] <= dIn[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      written   <= '0;
      dOut      <= '0;
      dOutEn    <= 1'b0;
      dOutValid <= 1'b0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (wrLaneEn[i]) written[wrIdx[i]] <= 1'b1;
      end
      dOutEn    <= strb.rdReq;
      dOutValid <= strb.rdReq && rdKnown;
      dOut      <= (strb.rdReq && rdKnown) ? rdBits : '0;
    end
  end
endmodule

// File: rtl/dualOrgSram.sv
module dualOrgSram
  import dosPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              wideMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        dIn,
  output logic [3:0]        dOut,
  output logic              dOutEn,
  output logic              dOutValid
);
  dosStrobes_t       strb;
  logic [ADDR_W-1:0] wAddr;

  dosControl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .oeN(oeN),
    .wideMode(wideMode), .addr(addr), .strb(strb), .wAddr(wAddr)
  );

  dosDatapath #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wAddr(wAddr),
    .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn), .dOutValid(dOutValid)
  );
endmodule

// File: rtl/dosChecker.sv
module dosChecker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              weN,
  input logic              oeN,
  input logic [ADDR_W-1:0] addr,
  input logic [3:0]        dOut,
  input logic              dOutEn,
  input logic              dOutValid
);
  p_deselect_hiz_r1: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !dOutEn);

  p_oe_high_hiz_r4: assert property (@(posedge clk) disable iff (!rstN)
    oeN |=> !dOutEn);

  p_write_hiz_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !weN) |=> !dOutEn);

  p_late_select_hiz_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csN) && !weN) |=> !dOutEn);

  p_masked_unknown_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dOutValid |-> (dOut == 4'b0000));

  p_valid_needs_drive_r9: assert property (@(posedge clk) disable iff (!rstN)
    dOutValid |-> dOutEn);

  p_addr_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !weN && $past(!csN && !weN)) |-> $stable(addr));
endmodule

bind dualOrgSram dosChecker #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/tb_dualOrgSram.sv
module tb_dualOrgSram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, weN = 1'b1, oeN = 1'b1, wideMode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] dIn = '0;
  logic [3:0] dOut;
  logic dOutEn, dOutValid;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit mMem [DEPTH];
  bit mWr  [DEPTH];
  bit mCsPrev = 1'b1, mActive = 1'b0, mWide = 1'b0, mBlock = 1'b0;
  int mAddr = 0;
  bit expEn = 1'b0, expValid = 1'b0;
  logic [3:0] expOut = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualOrgSram #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .oeN(oeN),
    .wideMode(wideMode), .addr(addr), .dIn(dIn),
    .dOut(dOut), .dOutEn(dOutEn), .dOutValid(dOutValid)
  );

  function automatic int cellOf(int a, bit wide, int lane);
    if (wide) return ((a % (DEPTH/4)) * 4) + lane;
    return a;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (dOutEn !== expEn || dOutValid !== expValid || dOut !== expOut) begin
      errors++;
      $display("FAIL %s: got en=%b valid=%b out=%b, expected en=%b valid=%b out=%b",
               tag, dOutEn, dOutValid, dOut, expEn, expValid, expOut);
    end
  endtask

  task automatic step(bit c, bit w, bit o, bit wide, int a, logic [3:0] d, string tag);
    bit act, com, blk, rd, known;
    logic [3:0] bits;
    csN = c; weN = w; oeN = o; wideMode = wide; addr = AW'(a); dIn = d;
    @(posedge clk);
    act = !c && !w;
    com = mActive && !act;
    if (c) blk = 1'b0;
    else if (mCsPrev && !w) blk = 1'b1;
    else blk = mBlock;
    rd = !c && w && !o && !blk;
    known = 1'b1;
    bits = '0;
    for (int i = 0; i < (wide ? 4 : 1); i++) begin
      bits[i] = mMem[cellOf(a, wide, i)];
      if (!mWr[cellOf(a, wide, i)]) known = 1'b0;
    end
    expEn = rd;
    expValid = rd && known;
    expOut = (rd && known) ? bits : 4'b0000;
    if (com) begin
      for (int i = 0; i < (mWide ? 4 : 1); i++) begin
        mMem[cellOf(mAddr, mWide, i)] = d[i];
        mWr[cellOf(mAddr, mWide, i)] = 1'b1;
      end
    end
    if (act) begin mAddr = a; mWide = wide; end
    mActive = act;
    mCsPrev = c;
    mBlock = blk;
    @(negedge clk);
    compare(tag);
  endtask

  // direct data check on top of the model comparison
  task automatic expectData(logic [3:0] want, string tag);
    checks++;
    if (dOutEn !== 1'b1 || dOutValid !== 1'b1 || dOut !== want) begin
      errors++;
      $display("FAIL %s: got en=%b valid=%b out=%b, expected en=1 valid=1 out=%b",
               tag, dOutEn, dOutValid, dOut, want);
    end
  endtask

  task automatic idle(string tag);
    step(1, 1, 1, 0, 0, 4'h0, tag);
  endtask

  // strobe-controlled narrow write: W low, then W high ends it
  task automatic writeNarrowW(int a, bit v);
    step(0, 1, 1, 0, a, 4'h0, "R2");
    step(0, 0, 1, 0, a, 4'h0, "R5");
    step(0, 1, 1, 0, a, {3'b000, v}, "R2");
    idle("R1");
  endtask

  task automatic writeWideW(int a, logic [3:0] v);
    step(0, 1, 1, 1, a, 4'h0, "R2");
    step(0, 0, 1, 1, a, 4'h0, "R5");
    step(0, 1, 1, 1, a, v, "R2");
    idle("R1");
  endtask

  task automatic readOnce(bit wide, int a, string tag);
    step(0, 1, 0, wide, a, 4'h0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    compare("R11 reset state");

    // R9: read before any write is masked
    readOnce(0, 5, "R9 unwritten narrow");
    idle("R1");

    // R2/R3/R6 narrow writes and reads
    writeNarrowW(5, 1'b1);
    writeNarrowW(6, 1'b0);
    writeNarrowW(200, 1'b1);
    readOnce(0, 5, "R3 narrow read");
    expectData(4'b0001, "R3");
    readOnce(0, 6, "R3 narrow read zero");
    expectData(4'b0000, "R3");
    readOnce(0, 200, "R6 narrow full range");
    expectData(4'b0001, "R6");

    // R8: wide word 1 = cells 4..7 ; cell 7 unwritten so masked
    readOnce(1, 1, "R9 partial wide");
    idle("R1");
    writeWideW(1, 4'b1010);
    readOnce(0, 5, "R8 wide then narrow");
    expectData(4'b0001, "R8");
    readOnce(0, 4, "R8 wide then narrow lane0");
    expectData(4'b0000, "R8");
    // R6: top two address bits ignored (1 + 192)
    readOnce(1, 193, "R6 wide top bits ignored");
    expectData(4'b1010, "R6");
    idle("R1");

    // narrow write then wide read
    writeNarrowW(4, 1'b1);
    readOnce(1, 1, "R8 narrow then wide");
    expectData(4'b1011, "R8");
    idle("R1");

    // R2: data at trailing edge, changing during the active phase
    step(0, 1, 1, 0, 10, 4'h0, "R2");
    step(0, 0, 1, 0, 10, 4'h1, "R5");
    step(0, 0, 1, 0, 10, 4'h1, "R5");
    step(0, 1, 1, 0, 10, 4'h0, "R2 trailing data");
    readOnce(0, 10, "R2 trailing data read");
    expectData(4'b0000, "R2");
    idle("R1");

    // R2: select-controlled ending, address changes once cs high
    step(0, 1, 1, 0, 11, 4'h0, "R2");
    step(0, 0, 0, 0, 11, 4'h0, "R5 oe low during write");
    step(1, 0, 0, 0, 99, 4'h1, "R2 select ends write");
    step(1, 1, 1, 0, 99, 4'h0, "R1");
    readOnce(0, 11, "R2 select-ended read");
    expectData(4'b0001, "R2");
    idle("R1");

    // R1: deselected with strobe low writes nothing
    step(1, 0, 0, 0, 11, 4'h0, "R1 deselected");
    step(1, 1, 0, 0, 11, 4'h0, "R1 deselected");
    readOnce(0, 11, "R1 no write");
    expectData(4'b0001, "R1");

    // R4: output enable high keeps bus released, no write
    step(0, 1, 1, 0, 11, 4'h0, "R4 oe high");
    readOnce(0, 11, "R4 data kept");
    expectData(4'b0001, "R4");
    idle("R1");

    // R12: strobe-ended write with oe low, read on commit edge
    step(0, 1, 1, 0, 6, 4'h0, "R12");
    step(0, 0, 0, 0, 6, 4'h0, "R5");
    step(0, 1, 0, 0, 6, 4'h1, "R12 commit edge read");
    expectData(4'b0000, "R12 old contents");
    readOnce(0, 6, "R12 next read");
    expectData(4'b0001, "R12 new contents");
    idle("R1");

    // R7: strobe low before select, then strobe rises with oe low
    step(1, 0, 0, 0, 20, 4'h0, "R7");
    step(0, 0, 0, 0, 20, 4'h0, "R7 late select");
    step(0, 1, 0, 0, 20, 4'h1, "R7 held released");
    step(0, 1, 0, 0, 20, 4'h0, "R7 held released");
    idle("R7 select high");
    readOnce(0, 20, "R7 write landed");
    expectData(4'b0001, "R7");
    // same edge select and strobe fall
    step(1, 1, 1, 0, 21, 4'h0, "R7");
    step(0, 0, 0, 0, 21, 4'h0, "R7 simultaneous");
    step(0, 1, 0, 0, 21, 4'h0, "R7 held released");
    idle("R1");

    // reset again clears written flags (R11)
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < DEPTH; i++) mWr[i] = 1'b0;
    mCsPrev = 1'b1; mActive = 1'b0; mWide = 1'b0; mBlock = 1'b0; mAddr = 0;
    expEn = 1'b0; expValid = 1'b0; expOut = '0;
    compare("R11 second reset");
    readOnce(0, 5, "R11 flags cleared");
    idle("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule